// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block sits between a clocked host and an external asynchronous static RAM of 131,072 bytes. The host issues one read or write at a time, with a 17-bit byte address and 8-bit write data. The controller drives the RAM's address, its two chip selects (one active low, one active high), its output enable and its write enable. All of these are registered, so the RAM sees no combinational glitches. The write data goes out on a data path that has its own drive-enable pin. The RAM's read data comes back on a separate input.

Every access is counted in clock cycles. The cycle counts are worked out when the block is elaborated, from the clock period and a speed-grade parameter. The slow grade assumes 100 ns read and write cycles. The fast grade assumes 85 ns cycles. A read holds the address and both selects for the whole cycle. It asserts output enable from the second cycle onward and samples the data bus on the final clock. It then returns the byte with a one-cycle valid pulse. A write drives the data from the first cycle and pulses write enable inside the window. Output enable stays inactive for the whole write. A one-cycle done pulse reports the end of the write.

Ready is high only while idle, and a request is accepted only while ready is high. At least one idle cycle separates any two accesses. As a result, the data driver is always off for at least one clock before output enable is asserted.

Top module: `sram_ctl`

## Requirements
- R1: After reset, ready is 1, the active-low select is 1, the active-high select is 0, output enable (active low) is 1, write enable (active low) is 1, and the data drive enable is 0.
- R2: The two selects are active (active-low select 0, active-high select 1) exactly during an accepted access. During that time the address output equals the requested address and does not change.
- R3: A read asserts output enable from its second cycle to its last cycle. In the slow grade at a 10 ns clock this is 9 cycles out of 10. The read samples the data input on the final clock of the access and returns it on rd_data with rd_valid high for exactly one cycle.
- R4: A write drives the data drive enable for the whole access, with the requested byte on the data output. It holds write enable low for one continuous run starting in the second cycle: 8 cycles in the slow grade at a 10 ns clock. Output enable stays high throughout the write.
- R5: Each write produces exactly one wr_done pulse, one cycle long, in the cycle after the final clock of the write. rd_valid and wr_done are never high together.
- R6: The data drive enable and an active output enable are never high in the same cycle. Output enable falls only after the drive enable has been low for at least one full cycle.
- R7: Ready goes low on the clock that accepts a request and stays low until the access's final clock. In the slow grade at 10 ns, that is 10 cycles for both reads and writes.
- R8: A request presented while ready is low is ignored. It changes no memory contents and adds no access.
- R9: With the fast-grade parameter set at a 10 ns clock, a read takes 9 cycles and write enable is low for 7 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while ready is high |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| ready | output | 1 | Idle and able to accept a request |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds read result |
| rd_data | output | 8 | Read result |
| wr_done | output | 1 | One-cycle pulse at write completion |
| mem_addr | output | 17 | RAM address |
| mem_sel_n | output | 1 | RAM select, active low |
| mem_sel | output | 1 | RAM select, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data returned from the RAM |

## Verification
If the cycle counter were wrong, the fault would appear at the ports within one access. Write enable would stay low for too few or too many cycles, ready would stay low for the wrong number of cycles, or the read would sample the RAM too early and return a stale or wrong byte that the scoreboard catches. If the operation state were wrong, output enable and the data drive could overlap. The bench would see that on the first read that follows a write. A request wrongly accepted while busy would show up as a changed memory byte on a later read-back.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 6;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic oe_n;
        logic we_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{sel_n: 1'b1, sel: 1'b0, oe_n: 1'b1,
                                        we_n: 1'b1, drive: 1'b0};

    function automatic int ns_to_cycles(int ns, int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // Minimum timings in ns for the two speed grades
    function automatic int t_cycle_ns(bit fast);
        return fast ? 85 : 100;
    endfunction

    function automatic int t_oe_ns(bit fast);
        return fast ? 45 : 50;
    endfunction

    function automatic int t_wpulse_ns(bit fast);
        return fast ? 60 : 70;
    endfunction

    function automatic int t_addr_to_wend_ns(bit fast);
        return fast ? 75 : 85;
    endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int RD_LAST = 9,
    parameter int WR_LAST = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output xfer_t             cur,
    output xfer_t             nxt,
    output logic              final_cyc,
    output logic              ready
);

    always_comb begin
        final_cyc = ((cur.op == OP_READ)  && (cur.cnt == CNT_W'(RD_LAST))) ||
                    ((cur.op == OP_WRITE) && (cur.cnt == CNT_W'(WR_LAST)));
        ready = (cur.op == OP_IDLE);
        nxt = cur;
        if (cur.op == OP_IDLE) begin
            if (req_valid) begin
                nxt.op    = req_write ? OP_WRITE : OP_READ;
                nxt.cnt   = '0;
                nxt.addr  = req_addr;
                nxt.wdata = req_wdata;
            end
        end else if (final_cyc) begin
            nxt.op  = OP_IDLE;
            nxt.cnt = '0;
        end else begin
            nxt.cnt = cur.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '{op: OP_IDLE, cnt: '0, addr: '0, wdata: '0};
        end else begin
            cur <= nxt;
        end
    end

    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (rst)
        (!ready && req_valid && !final_cyc) |=> ($stable(cur.addr) && $stable(cur.op))) // R8
        else $error("request taken while busy");

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (cur.op != OP_IDLE) |-> (cur.cnt <= CNT_W'(max2(RD_LAST, WR_LAST)))) // R7
        else $error("access counter overran");

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
    import sram_ctl_pkg::*;
#(
    parameter int OE_FIRST = 1,
    parameter int WE_FIRST = 1,
    parameter int WE_LAST  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_t             nxt,
    input  op_e               cur_op,
    input  logic              final_cyc,
    input  logic [DATA_W-1:0] mem_dq_in,
    output strobe_t           pins,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_done
);

    strobe_t pins_d;

    always_comb begin
        pins_d = STROBE_IDLE;
        if (nxt.op != OP_IDLE) begin
            pins_d.sel_n = 1'b0;
            pins_d.sel   = 1'b1;
        end
        if (nxt.op == OP_READ && nxt.cnt >= CNT_W'(OE_FIRST)) begin
            pins_d.oe_n = 1'b0;
        end
        if (nxt.op == OP_WRITE) begin
            pins_d.drive = 1'b1;
            if (nxt.cnt >= CNT_W'(WE_FIRST) && nxt.cnt <= CNT_W'(WE_LAST)) begin
                pins_d.we_n = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pins       <= STROBE_IDLE;
            mem_addr   <= '0;
            mem_dq_out <= '0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            wr_done    <= 1'b0;
        end else begin
            pins       <= pins_d;
            mem_addr   <= nxt.addr;
            mem_dq_out <= nxt.wdata;
            rd_valid   <= (cur_op == OP_READ) && final_cyc;
            wr_done    <= (cur_op == OP_WRITE) && final_cyc;
            if ((cur_op == OP_READ) && final_cyc) begin
                rd_data <= mem_dq_in;
            end
        end
    end

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        pins.drive |-> pins.oe_n) // R6
        else $error("driver on while RAM output enabled");

    AST_RELEASE_BEFORE_OE: assert property (@(posedge clk) disable iff (rst)
        $fell(pins.oe_n) |-> !$past(pins.drive)) // R6
        else $error("output enable right after driving");

    AST_STROBE_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
        (!pins.we_n || !pins.oe_n) |-> (!pins.sel_n && pins.sel)) // R2
        else $error("strobe without chip select");

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!pins.sel_n && $past(!pins.sel_n)) |-> $stable(mem_addr)) // R2
        else $error("address moved mid-access");

    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!pins.oe_n && !pins.we_n)) // R4
        else $error("output and write enable together");

    AST_ONE_DONE: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && wr_done)) // R5
        else $error("read and write completion together");

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_NS     = 10,
    parameter bit FAST_GRADE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int OE_FIRST = 1;
    localparam int WE_FIRST = 1;
    localparam int RD_CYC   = max2(ns_to_cycles(t_cycle_ns(FAST_GRADE), CLK_NS),
                                   OE_FIRST + ns_to_cycles(t_oe_ns(FAST_GRADE), CLK_NS));
    localparam int WE_CYC   = max2(ns_to_cycles(t_wpulse_ns(FAST_GRADE), CLK_NS),
                                   ns_to_cycles(t_addr_to_wend_ns(FAST_GRADE), CLK_NS) - WE_FIRST);
    localparam int WR_CYC   = max2(ns_to_cycles(t_cycle_ns(FAST_GRADE), CLK_NS),
                                   WE_FIRST + WE_CYC + 1);
    localparam int RD_LAST  = RD_CYC - 1;
    localparam int WR_LAST  = WR_CYC - 1;
    localparam int WE_LAST  = WE_FIRST + WE_CYC - 1;

    xfer_t   cur;
    xfer_t   nxt;
    logic    final_cyc;
    strobe_t pins;

    sram_ctl_seq #(
        .RD_LAST (RD_LAST),
        .WR_LAST (WR_LAST)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cur       (cur),
        .nxt       (nxt),
        .final_cyc (final_cyc),
        .ready     (ready)
    );

    sram_ctl_pins #(
        .OE_FIRST (OE_FIRST),
        .WE_FIRST (WE_FIRST),
        .WE_LAST  (WE_LAST)
    ) u_pins (
        .clk        (clk),
        .rst        (rst),
        .nxt        (nxt),
        .cur_op     (cur.op),
        .final_cyc  (final_cyc),
        .mem_dq_in  (mem_dq_in),
        .pins       (pins),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .wr_done    (wr_done)
    );

    assign mem_sel_n = pins.sel_n;
    assign mem_sel   = pins.sel;
    assign mem_oe_n  = pins.oe_n;
    assign mem_we_n  = pins.we_n;
    assign mem_dq_oe = pins.drive;

endmodule

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, rd_valid, wr_done;
    logic [7:0]  rd_data;
    logic [16:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out, mem_dq_in;

    // fast-grade instance
    logic        f_req_valid = 1'b0;
    logic        f_req_write = 1'b0;
    logic [16:0] f_req_addr = '0;
    logic        f_ready, f_rd_valid, f_wr_done;
    logic [7:0]  f_rd_data;
    logic [16:0] f_mem_addr;
    logic        f_sel_n, f_sel, f_oe_n, f_we_n, f_dq_oe;
    logic [7:0]  f_dq_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0]  ram [logic [16:0]];
    logic [7:0]  ref_mem [logic [16:0]];
    logic [7:0]  exp_q [$];
    logic [16:0] cur_req_addr = '0;
    int          pending_wr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_ctl #(.CLK_NS(CLK_PERIOD), .FAST_GRADE(1'b0)) u_sram_ctl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_done(wr_done),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    sram_ctl #(.CLK_NS(CLK_PERIOD), .FAST_GRADE(1'b1)) u_sram_ctl_fast (
        .clk(clk), .rst(rst), .req_valid(f_req_valid), .req_write(f_req_write),
        .req_addr(f_req_addr), .req_wdata(8'h11), .ready(f_ready),
        .rd_valid(f_rd_valid), .rd_data(f_rd_data), .wr_done(f_wr_done),
        .mem_addr(f_mem_addr), .mem_sel_n(f_sel_n), .mem_sel(f_sel),
        .mem_oe_n(f_oe_n), .mem_we_n(f_we_n), .mem_dq_out(f_dq_out),
        .mem_dq_oe(f_dq_oe), .mem_dq_in(8'hC3)
    );

    function automatic logic [7:0] ram_rd(logic [16:0] a);
        if (ram.exists(a)) return ram[a];
        return 8'h5A;
    endfunction

    function automatic logic [7:0] ref_rd(logic [16:0] a);
        if (ref_mem.exists(a)) return ref_mem[a];
        return 8'h5A;
    endfunction

    // RAM model: drives only while selected with output enabled and no write
    assign mem_dq_in = (!mem_sel_n && mem_sel && !mem_oe_n && mem_we_n) ?
                       ram_rd(mem_addr) : 8'hEE;

    always @(posedge mem_we_n) begin
        if (rst === 1'b0 && mem_sel_n === 1'b0 && mem_sel === 1'b1)
            ram[mem_addr] = mem_dq_out;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: waits for ready, presents one request for one cycle
    task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        cur_req_addr = a;
        if (wr) begin
            ref_mem[a] = d;
            pending_wr++;
        end else begin
            exp_q.push_back(ref_rd(a));
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Request held while busy: must be ignored (R8)
    task automatic poke_busy(input logic [16:0] a, input logic [7:0] d);
        check(!ready, "R8 poke while busy", ready, 0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: scoreboard and strobe shape measurements
    int  we_run = 0, oe_run = 0, busy_run = 0, gap = 100;
    bit  addr_bad = 1'b0, prev_rv = 1'b0, prev_wd = 1'b0;
    bit  in_write = 1'b0;
    int  overlap = 0, we_runs_seen = 0, rd_seen = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_dq_oe && !mem_oe_n) overlap++;
            if (!mem_we_n) we_run++;
            else if (we_run != 0) begin
                check(we_run == 8, "R4 write-enable width", we_run, 8);
                we_runs_seen++;
                we_run = 0;
            end
            if (!mem_oe_n) begin
                if (oe_run == 0) check(gap >= 1, "R6 release before output enable", gap, 1);
                oe_run++;
            end else if (oe_run != 0) begin
                check(oe_run == 9, "R3 output-enable width", oe_run, 9);
                oe_run = 0;
            end
            gap = mem_dq_oe ? 0 : gap + 1;
            if (mem_dq_oe) begin
                in_write = 1'b1;
                if (!mem_oe_n) check(0, "R4 output enable high in write", 0, 1);
            end
            if (!ready) begin
                busy_run++;
                if (!(!mem_sel_n && mem_sel) || mem_addr != cur_req_addr) addr_bad = 1'b1;
            end else if (busy_run != 0) begin
                check(busy_run == 10, "R7 ready-low length", busy_run, 10);
                check(!addr_bad, "R2 selects and address held", addr_bad, 0);
                check(mem_sel_n && !mem_sel, "R2 deselect after access", mem_sel, 0);
                busy_run = 0; addr_bad = 1'b0; in_write = 1'b0;
            end
            if (rd_valid) begin
                rd_seen++;
                check(!prev_rv, "R3 rd_valid single cycle", prev_rv, 0);
                if (exp_q.size() == 0) check(0, "R3 unexpected rd_valid", 1, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(rd_data == e, "R3 read data", rd_data, e);
                end
            end
            if (wr_done) begin
                check(!prev_wd && pending_wr > 0, "R5 wr_done pulse", pending_wr, 1);
                pending_wr--;
            end
            prev_rv = rd_valid;
            prev_wd = wr_done;
        end
    end

    int f_we_run = 0, f_busy = 0, f_we_max = 0, f_busy_last = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!f_we_n) f_we_run++;
            else if (f_we_run != 0) begin f_we_max = f_we_run; f_we_run = 0; end
            if (!f_ready) f_busy++;
            else if (f_busy != 0) begin f_busy_last = f_busy; f_busy = 0; end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(ready == 1'b1, "R1 ready", ready, 1);
        check(mem_sel_n == 1'b1 && mem_sel == 1'b0, "R1 selects idle", mem_sel, 0);
        check(mem_oe_n == 1'b1 && mem_we_n == 1'b1, "R1 strobes high", mem_we_n, 1);
        check(mem_dq_oe == 1'b0, "R1 driver off", mem_dq_oe, 0);

        // writes at boundary and middle addresses, then reads (R3, R4, R5)
        issue(1'b1, 17'h00000, 8'hA5);
        issue(1'b1, 17'h1FFFF, 8'h3C);
        issue(1'b1, 17'h0ABCD, 8'hFF);
        issue(1'b0, 17'h00000, 8'h00);   // read right after write (R6)
        issue(1'b0, 17'h1FFFF, 8'h00);
        issue(1'b0, 17'h0ABCD, 8'h00);
        issue(1'b0, 17'h12345, 8'h00);   // never written
        // alternating pattern, write then immediately read
        for (int i = 0; i < 6; i++) begin
            issue(1'b1, 17'(17'h01000 + i * 17'h3333), 8'(8'h0F << (i % 4)) ^ 8'(i));
            issue(1'b0, 17'(17'h01000 + i * 17'h3333), 8'h00);
        end
        // R8: requests while busy are ignored
        issue(1'b0, 17'h00000, 8'h00);
        poke_busy(17'h00000, 8'h77);
        issue(1'b1, 17'h1FFFF, 8'h81);
        poke_busy(17'h0ABCD, 8'h99);
        issue(1'b0, 17'h00000, 8'h00);   // still A5
        issue(1'b0, 17'h0ABCD, 8'h00);   // still FF
        issue(1'b0, 17'h1FFFF, 8'h00);   // 81

        while (!ready || exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(overlap == 0, "R6 no overlap of drive and output enable", overlap, 0);
        check(rd_seen == 14, "R3 read count", rd_seen, 14);
        check(pending_wr == 0, "R5 every write completed", pending_wr, 0);
        check(we_runs_seen == 10, "R4 write pulses", we_runs_seen, 10);

        // R9 fast grade
        @(negedge clk);
        f_req_valid = 1'b1; f_req_write = 1'b1; f_req_addr = 17'h00042;
        @(negedge clk);
        f_req_valid = 1'b0;
        while (!f_ready) @(negedge clk);
        @(negedge clk);
        check(f_we_max == 7, "R9 fast write-enable width", f_we_max, 7);
        f_req_valid = 1'b1; f_req_write = 1'b0;
        @(negedge clk);
        f_req_valid = 1'b0;
        while (!f_ready) @(negedge clk);
        check(f_rd_valid == 1'b1 && f_rd_data == 8'hC3, "R9 fast read data", f_rd_data, 8'hC3);
        @(negedge clk);
        check(f_busy_last == 9, "R9 fast read length", f_busy_last, 9);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule